// File: doc/BRIEF.md
# Inline Block-Move List Executor

This block is a memory-to-memory copy engine driven by a list held in memory. Software places a chain of move records in a control block and hands the engine the base address of that chain together with a start pulse. The engine then owns a single word-wide memory port with a request/ready handshake. It reads each record's word count and target address, and copies the data words that sit directly after them in the list to that target.

A record with a count of zero closes the chain. When the engine reaches it, the engine raises a one-cycle completion pulse and presents the number of words it wrote. A start is honoured only when the run-enable bit taken from the caller's status word is set. A parameterised ceiling on the number of records stops a chain that never terminates and raises an error flag.

Top module: `pcb_move_exec`

## Requirements
- R1: A start pulse is accepted only while the engine is idle and `status_go` is 1; a start with `status_go` at 0 causes no memory request and leaves `busy` at 0.
- R2: Each record is read from the list as a word count, then a destination address one word later, then that many data words; the memory port issues only reads of the list and writes to destinations, in that order.
- R3: The list read address starts at `list_base` and rises by 4 after every completed list read, with no gaps, including across record boundaries.
- R4: Data moves one word at a time, a list read followed by a write; the i-th word of a record (i from 0) is written to its destination address plus 4*i.
- R5: A record whose count word is 0 ends the list; after it no further memory request is made, and a list that starts with it completes with `words_moved` equal to 0.
- R6: While `mem_req` is 1 and `mem_ready` is 0, the request stays asserted with `mem_addr`, `mem_we` and `mem_wdata` unchanged; a transfer completes on a cycle where both are 1, and read data is taken from `mem_rdata` on that cycle.
- R7: `done` is 1 for exactly one cycle when the list ends; `words_moved` then equals the total number of words written, holds until the next accepted start, and is cleared by that start.
- R8: When a nonzero count word is read after MAX_RECORDS records have been moved, the engine makes no further request, sets `limit_err`, and pulses `done`; `limit_err` is cleared by the next accepted start.
- R9: A start pulse while the engine is busy is ignored and does not disturb the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request pulse |
| status_go | input | 1 | Run-enable bit of the caller's status word |
| list_base | input | AW | Byte address of the first record |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Transfer completes when high together with `mem_req` |
| busy | output | 1 | Engine is walking a list |
| done | output | 1 | One-cycle end-of-list pulse |
| limit_err | output | 1 | Record ceiling was exceeded |
| words_moved | output | CW | Words written in the last run |

## Verification
The bench builds the engine with a 16-bit address, 32-bit words and MAX_RECORDS set to 3, so a four-record chain reaches the ceiling after a handful of transfers instead of hundreds. It runs chains with records of one to four words under both an always-ready port and a port that stalls two cycles in three, which brings the hold rule and record-boundary address steps into view. A zero-length chain, a start with the enable bit clear and a start issued mid-run cover the remaining corners.

// File: rtl/bme_pkg.sv
package bme_pkg;
  localparam int WORD_BYTES = 4;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_SIZE  = 3'd1,
    S_DEST  = 3'd2,
    S_READ  = 3'd3,
    S_WRITE = 3'd4
  } bme_state_e;
endpackage

// File: rtl/bme_ptr.sv
module bme_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_rd,
  input  logic [AW-1:0] base,
  input  logic          rd_adv,
  input  logic          load_wr,
  input  logic [AW-1:0] dest,
  input  logic          wr_adv,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_ptr
);
  import bme_pkg::*;

  function automatic logic [AW-1:0] next_word(input logic [AW-1:0] a);
    return a + AW'(WORD_BYTES);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      if (load_rd)     rd_ptr <= base;
      else if (rd_adv) rd_ptr <= next_word(rd_ptr);
      if (load_wr)     wr_ptr <= dest;
      else if (wr_adv) wr_ptr <= next_word(wr_ptr);
    end
  end

  // R3: list pointer only moves on a load or a completed read
  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rd && !rd_adv |=> $stable(rd_ptr));
  // R4: destination pointer only moves on a load or a completed write
  p_wr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_wr && !wr_adv |=> $stable(wr_ptr));
endmodule

// File: rtl/bme_count.sv
module bme_count #(
  parameter int CW   = 16,
  parameter int RCW  = 9,
  parameter int RMAX = 256
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           word_inc,
  input  logic           rec_inc,
  output logic [CW-1:0]  words,
  output logic [RCW-1:0] recs
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words <= '0;
      recs  <= '0;
    end else if (clear) begin
      words <= '0;
      recs  <= '0;
    end else begin
      if (word_inc) words <= words + CW'(1);
      if (rec_inc)  recs  <= recs + RCW'(1);
    end
  end

  // R8: the record tally never passes the ceiling
  p_rec_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    recs <= RCW'(RMAX));
endmodule

// File: rtl/pcb_move_exec.sv
module pcb_move_exec #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int CW          = 16,
  parameter int MAX_RECORDS = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          status_go,
  input  logic [AW-1:0] list_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          done,
  output logic          limit_err,
  output logic [CW-1:0] words_moved
);
  import bme_pkg::*;

  localparam int RCW = $clog2(MAX_RECORDS + 1);

  bme_state_e     state_q;
  logic [DW-1:0]  remain_q;
  logic [DW-1:0]  data_q;
  logic           done_q;
  logic           err_q;
  logic [AW-1:0]  rd_ptr, wr_ptr;
  logic [RCW-1:0] rec_cnt;

  // named internal events
  logic hs, accept, rd_adv, wr_adv, load_wr, size_zero, at_limit, rec_inc, last_word;

  function automatic logic is_last(input logic [DW-1:0] r);
    return r == DW'(1);
  endfunction

  assign hs        = mem_req && mem_ready;
  assign accept    = (state_q == S_IDLE) && start && status_go;
  assign size_zero = (mem_rdata == '0);
  assign at_limit  = (rec_cnt == RCW'(MAX_RECORDS));
  assign rd_adv    = hs && (state_q inside {S_SIZE, S_DEST, S_READ});
  assign wr_adv    = hs && (state_q == S_WRITE);
  assign load_wr   = hs && (state_q == S_DEST);
  assign rec_inc   = hs && (state_q == S_SIZE) && !size_zero && !at_limit;
  assign last_word = is_last(remain_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      remain_q <= '0;
      data_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            err_q   <= 1'b0;
            state_q <= S_SIZE;
          end
        end
        S_SIZE: begin
          if (hs) begin
            if (size_zero) begin
              done_q  <= 1'b1;
              state_q <= S_IDLE;
            end else if (at_limit) begin
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              remain_q <= mem_rdata;
              state_q  <= S_DEST;
            end
          end
        end
        S_DEST: if (hs) state_q <= S_READ;
        S_READ: begin
          if (hs) begin
            data_q  <= mem_rdata;
            state_q <= S_WRITE;
          end
        end
        S_WRITE: begin
          if (hs) begin
            remain_q <= remain_q - DW'(1);
            state_q  <= last_word ? S_SIZE : S_READ;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  bme_ptr #(.AW(AW)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_rd(accept),
    .base   (list_base),
    .rd_adv (rd_adv),
    .load_wr(load_wr),
    .dest   (mem_rdata[AW-1:0]),
    .wr_adv (wr_adv),
    .rd_ptr (rd_ptr),
    .wr_ptr (wr_ptr)
  );

  bme_count #(.CW(CW), .RCW(RCW), .RMAX(MAX_RECORDS)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .word_inc(wr_adv),
    .rec_inc (rec_inc),
    .words   (words_moved),
    .recs    (rec_cnt)
  );

  assign busy      = (state_q != S_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (state_q == S_WRITE);
  assign mem_addr  = mem_we ? wr_ptr : rd_ptr;
  assign mem_wdata = data_q;
  assign done      = done_q;
  assign limit_err = err_q;

  // R1: a start without the enable bit leaves the engine idle
  p_go_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !status_go |=> !busy);
  // R5: no request accompanies the end pulse
  p_quiet_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
  // R6: a stalled request keeps its command, address and data
  p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: the word total holds while idle without a start
  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(start && status_go) |=> $stable(words_moved));
  // R8: the error flag only appears with the end pulse
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(limit_err) |-> done);
endmodule

// File: tb/pcb_move_exec_test.sv
`timescale 1ns/1ps
module pcb_move_exec_test;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam int MAXR = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          status_go = 1'b0;
  logic [AW-1:0] list_base = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_ready = 1'b0;
  logic          busy, done, limit_err;
  logic [CW-1:0] words_moved;

  always #2.5 clk = ~clk;

  pcb_move_exec #(.AW(AW), .DW(DW), .CW(CW), .MAX_RECORDS(MAXR)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .status_go(status_go),
    .list_base(list_base), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .busy(busy), .done(done), .limit_err(limit_err),
    .words_moved(words_moved)
  );

  typedef struct {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } txn_t;

  logic [DW-1:0] mem [0:4095];
  txn_t expq[$];
  txn_t chkq[$];
  int errors = 0;
  int checks = 0;
  int slow_mode = 0;
  int cyc = 0;
  logic          prev_stall = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic          prev_we = 1'b0;

  assign mem_rdata = mem[mem_addr[13:2]];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready pattern, changed on the active edge so it is steady all cycle
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= (slow_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
  end

  // reference transaction model, compared every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && mem_req)
        check(mem_addr == prev_addr && mem_we == prev_we, "R6 stalled request held", mem_addr, prev_addr);
      prev_stall = mem_req && !mem_ready;
      prev_addr  = mem_addr;
      prev_we    = mem_we;
      if (mem_req && mem_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R5 unexpected access", mem_addr, 0);
        end else begin
          txn_t e;
          e = expq.pop_front();
          check(mem_we == e.we, "R2 access kind", mem_we, e.we);
          check(mem_addr == e.addr, e.we ? "R4 write address" : "R3 read address", mem_addr, e.addr);
          if (e.we) begin
            check(mem_wdata == e.data, "R4 write data", mem_wdata, e.data);
            mem[mem_addr[13:2]] = mem_wdata;
          end
        end
      end
    end
  end

  task automatic pulse_start(input logic [AW-1:0] base, input logic go);
    @(negedge clk);
    list_base = base;
    status_go = go;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // builds a chain, queues expected traffic, runs it and checks the result
  task automatic run_list(input int base, input int n, input int sizes[6],
                          input int dest_base, input bit mid_start);
    int a = base;
    int d = dest_base;
    int exp_words = 0;
    int waitc = 0;
    bit exp_err = (n > MAXR);
    for (int r = 0; r < n; r++) begin
      mem[a[13:2]] = sizes[r];
      expq.push_back('{1'b0, AW'(a), '0});
      a += 4;
      if (r >= MAXR) break;
      mem[a[13:2]] = d;
      expq.push_back('{1'b0, AW'(a), '0});
      a += 4;
      for (int i = 0; i < sizes[r]; i++) begin
        logic [DW-1:0] v = 32'hC0DE_0000 + DW'(base) + DW'(r * 16 + i);
        mem[a[13:2]] = v;
        expq.push_back('{1'b0, AW'(a), '0});
        expq.push_back('{1'b1, AW'(d + 4 * i), v});
        chkq.push_back('{1'b1, AW'(d + 4 * i), v});
        a += 4;
        exp_words++;
      end
      d += 256;
    end
    if (!exp_err) begin
      mem[a[13:2]] = 0;
      expq.push_back('{1'b0, AW'(a), '0});
    end
    pulse_start(AW'(base), 1'b1);
    check(busy == 1'b1 && words_moved == 0, "R7 start clears count", words_moved, 0);
    if (mid_start) begin
      repeat (2) @(negedge clk);
      pulse_start(AW'(16'h3F00), 1'b1); // R9: must not redirect the run
    end
    while (!done && waitc < 2000) begin
      @(negedge clk);
      waitc++;
    end
    check(done == 1'b1, "R7 done raised", done, 1);
    check(words_moved == CW'(exp_words), "R7 word total", words_moved, exp_words);
    check(limit_err == exp_err, "R8 limit flag", limit_err, exp_err);
    check(expq.size() == 0, "R2 all expected accesses seen", expq.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    repeat (4) @(negedge clk);
    check(words_moved == CW'(exp_words) && !busy, "R7 total held after end", words_moved, exp_words);
    while (chkq.size() > 0) begin
      txn_t c = chkq.pop_front();
      check(mem[c.addr[13:2]] == c.data, "R4 destination contents", mem[c.addr[13:2]], c.data);
    end
    expq.delete();
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req && !limit_err && words_moved == 0, "R7 reset state", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: start with enable bit clear is ignored
    pulse_start(AW'(16'h0100), 1'b0);
    repeat (4) begin
      @(negedge clk);
      check(!busy && !mem_req, "R1 start without enable ignored", busy, 0);
    end

    // R5: empty chain
    run_list(16'h0200, 0, '{0, 0, 0, 0, 0, 0}, 16'h2000, 1'b0);
    // R2/R3/R4: two records, always ready
    run_list(16'h0300, 2, '{1, 3, 0, 0, 0, 0}, 16'h2400, 1'b0);
    // R6: stalling port, three records
    slow_mode = 1;
    run_list(16'h0400, 3, '{2, 1, 4, 0, 0, 0}, 16'h2800, 1'b0);
    // R9: start pulse mid-run
    run_list(16'h0500, 2, '{3, 2, 0, 0, 0, 0}, 16'h2C00, 1'b1);
    // R8: ceiling exceeded
    slow_mode = 0;
    run_list(16'h0600, 4, '{1, 2, 1, 2, 0, 0}, 16'h3000, 1'b0);
    // R8: next start clears the flag
    run_list(16'h0700, 1, '{2, 0, 0, 0, 0, 0}, 16'h3400, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule